// File: doc/BRIEF.md
# Adaptive Write-Run Coherence Mode Selector

This block sits next to a snooping cache's coherence controller. For every local write to a shared line it decides, in the same cycle as the write, whether the write goes onto the bus as a write-update or as a write-invalidate. A write-update carries the new data and also refreshes memory. A write-invalidate carries only the address and leaves memory stale. The choice is made while the system runs, not fixed when the chip is designed. It is driven by how long this processor's writes to the line tend to run before anything interrupts them.

A write run is a sequence of local writes to one line with no access to that line by another processor and no replacement of the line in between. A small table, indexed by line number, holds two things for each line: a 3-bit saturating count of writes in the current run, and a mode bit. When the count reaches a programmable threshold, the line switches to invalidate, because long runs favour invalidation. When a run ends, the count clears. The mode bit then records whether that run reached the threshold, and the next run starts with that prediction. Short runs therefore put the line back into update mode.

Top module: `wrun_mode_sel`

## Requirements
- R1: After reset every line is in update mode with a run count of zero. With no write pending, `bus_req_o` is 2'b00 and `mem_upd_o` is 0.
- R2: `bus_req_o` is driven in the same cycle as `wr_valid_i`. It is 2'b01 for a write-update and 2'b10 for a write-invalidate. It is 2'b00 whenever `wr_valid_i` is low.
- R3: `mem_upd_o` is high exactly when the current write is sent as a write-update. `inval_o` is high exactly when it is sent as a write-invalidate.
- R4: A write is sent as a write-invalidate if its line is in invalidate mode, or if the line's run count before this write is greater than or equal to `thr_i`. Once that count reaches `thr_i`, the line enters invalidate mode.
- R5: Each local write that does not end its run adds one to the line's run count. The count saturates at 7 and never wraps.
- R6: A snooped access (`snp_valid_i`) to a line ends its run. The count becomes 0, and the mode becomes invalidate if the run length is greater than or equal to `thr_i`, otherwise update. A local write to the same line in the same cycle counts toward that run length.
- R7: A replacement (`rpl_valid_i`) of a line ends its run with the same effect as R6.
- R8: Writes, snoops and replacements to one line leave the count and mode of every other line unchanged.
- R9: With `thr_i` equal to 0, every local write is sent as a write-invalidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_i | input | 3 | Run-length threshold for invalidate mode |
| wr_valid_i | input | 1 | Local write strobe |
| wr_line_i | input | LINE_W | Line index of the local write |
| snp_valid_i | input | 1 | Snooped access by another processor |
| snp_line_i | input | LINE_W | Line index of the snooped access |
| rpl_valid_i | input | 1 | Line replacement strobe |
| rpl_line_i | input | LINE_W | Line index being replaced |
| inval_o | output | 1 | Current write is sent as a write-invalidate |
| bus_req_o | output | 2 | Bus request type: 00 none, 01 update, 10 invalidate |
| mem_upd_o | output | 1 | Current write also updates memory |

## Verification
The assertions check on every cycle that the bus request is idle without a write, that the memory-update flag agrees with the request type, and that a zero threshold always yields invalidation. For each line they also check that a run end clears the count, that a count at its ceiling stays there, and that reaching the threshold sets invalidate mode. The bench scenarios are needed to show behaviour across whole runs: that the mode carried into the next run depends on the length of the run that ended, that a write arriving together with a snoop counts toward the run, that saturation keeps the run length, and that events on one line leave the others alone.

// File: rtl/wrsel_pkg.sv
package wrsel_pkg;

    localparam int CNT_W   = 3;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        BREQ_NONE = 2'b00,
        BREQ_UPD  = 2'b01,
        BREQ_INV  = 2'b10
    } breq_e;

    // per-line tracking state
    typedef struct packed {
        logic inv_mode;
        cnt_t cnt;
    } line_st_t;

    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == cnt_t'(CNT_MAX)) ? v : v + cnt_t'(1);
    endfunction

endpackage

// File: rtl/wrsel_line.sv
module wrsel_line
    import wrsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_hit,
    input  logic     end_hit,
    input  cnt_t     thr,
    output line_st_t st_q
);

    cnt_t     run_len;
    line_st_t st_d;

    always_comb begin
        run_len = wr_hit ? sat_inc(st_q.cnt) : st_q.cnt;
        st_d    = st_q;
        if (end_hit) begin
            st_d.cnt      = '0;
            st_d.inv_mode = (run_len >= thr);
        end else if (wr_hit) begin
            st_d.cnt = run_len;
            if (st_q.cnt >= thr)
                st_d.inv_mode = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R6/R7: a run end clears the count
    a_r6_end_clears: assert property (@(posedge clk) disable iff (rst)
        end_hit |=> (st_q.cnt == '0));

    // R5: saturation, never wrap
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !end_hit && st_q.cnt == cnt_t'(CNT_MAX)) |=> (st_q.cnt == cnt_t'(CNT_MAX)));

    // R4: reaching threshold sets invalidate mode
    a_r4_enter_inv: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !end_hit && st_q.cnt >= thr) |=> st_q.inv_mode);

endmodule

// File: rtl/wrsel_pick.sv
module wrsel_pick
    import wrsel_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  line_st_t [NUM_LINES-1:0] st_all,
    input  logic                     wr_valid,
    input  logic [LINE_W-1:0]        wr_line,
    input  cnt_t                     thr,
    output logic                     inval,
    output breq_e                    req,
    output logic                     mem_upd
);

    line_st_t cur;

    always_comb begin
        cur     = st_all[wr_line];
        inval   = wr_valid & (cur.inv_mode | (cur.cnt >= thr));
        mem_upd = wr_valid & ~inval;
        if (!wr_valid)  req = BREQ_NONE;
        else if (inval) req = BREQ_INV;
        else            req = BREQ_UPD;
    end

endmodule

// File: rtl/wrun_mode_sel.sv
module wrun_mode_sel
    import wrsel_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        thr_i,
    input  logic              wr_valid_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic              snp_valid_i,
    input  logic [LINE_W-1:0] snp_line_i,
    input  logic              rpl_valid_i,
    input  logic [LINE_W-1:0] rpl_line_i,
    output logic              inval_o,
    output logic [1:0]        bus_req_o,
    output logic              mem_upd_o
);

    line_st_t [NUM_LINES-1:0] st_all;
    breq_e                    req;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic wr_hit, end_hit;
        assign wr_hit  = wr_valid_i  && (wr_line_i  == LINE_W'(i));
        assign end_hit = (snp_valid_i && (snp_line_i == LINE_W'(i)))
                      || (rpl_valid_i && (rpl_line_i == LINE_W'(i)));
        wrsel_line u_line (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_hit),
            .end_hit (end_hit),
            .thr     (thr_i),
            .st_q    (st_all[i])
        );
    end

    wrsel_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .st_all   (st_all),
        .wr_valid (wr_valid_i),
        .wr_line  (wr_line_i),
        .thr      (thr_i),
        .inval    (inval_o),
        .req      (req),
        .mem_upd  (mem_upd_o)
    );

    assign bus_req_o = req;

    a_r2_idle_no_req: assert property (@(posedge clk) disable iff (rst)
        !wr_valid_i |-> (bus_req_o == 2'b00));

    a_r3_mem_matches_req: assert property (@(posedge clk) disable iff (rst)
        mem_upd_o == (bus_req_o == 2'b01));

    a_r3_inval_matches_req: assert property (@(posedge clk) disable iff (rst)
        inval_o == (bus_req_o == 2'b10));

    a_r9_zero_thr_inv: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_i && thr_i == 3'd0) |-> (bus_req_o == 2'b10));

endmodule

// File: tb/wrun_mode_sel_tb.sv
module wrun_mode_sel_tb;

    localparam logic [1:0] N = 2'b00, U = 2'b01, I = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] thr = 3'd3;
    logic       wr_v = 1'b0, sn_v = 1'b0, rp_v = 1'b0;
    logic [2:0] wr_l = '0, sn_l = '0, rp_l = '0;
    logic       inval, mem_upd;
    logic [1:0] req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wrun_mode_sel #(.NUM_LINES(8)) u_dut (
        .clk(clk), .rst(rst), .thr_i(thr),
        .wr_valid_i(wr_v), .wr_line_i(wr_l),
        .snp_valid_i(sn_v), .snp_line_i(sn_l),
        .rpl_valid_i(rp_v), .rpl_line_i(rp_l),
        .inval_o(inval), .bus_req_o(req), .mem_upd_o(mem_upd)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check outputs before the next posedge
    task automatic step(input bit wv, input int wl, input bit sv, input int sl,
                        input bit rv, input int rl, input logic [1:0] exp, input string tag);
        @(negedge clk);
        wr_v = wv; wr_l = 3'(wl);
        sn_v = sv; sn_l = 3'(sl);
        rp_v = rv; rp_l = 3'(rl);
        #1;
        check(tag, req, exp);
        check({tag, " R3 mem/inval"}, {inval, mem_upd}, {exp == I, exp == U});
    endtask

    task automatic wr(input int l, input logic [1:0] exp, input string tag);
        step(1, l, 0, 0, 0, 0, exp, tag);
    endtask

    task automatic t_reset();
        step(0, 0, 0, 0, 0, 0, N, "R1 idle after reset");
        thr = 3'd3;
        wr(0, U, "R1 first write update");
        step(0, 0, 1, 1, 1, 2, N, "R2 no write no req");
    endtask

    task automatic t_run();
        thr = 3'd3;
        wr(1, U, "R4 run cnt0");
        wr(1, U, "R5 run cnt1");
        wr(1, U, "R5 run cnt2");
        wr(1, I, "R4 run cnt3 reaches thr");
        wr(1, I, "R4 run cnt4");
        step(0, 0, 1, 1, 0, 0, N, "R6 snoop end long");
        wr(1, I, "R6 long run keeps invalidate");
        step(0, 0, 1, 1, 0, 0, N, "R6 snoop end short");
        wr(1, U, "R6 short run back to update");
    endtask

    task automatic t_repl();
        thr = 3'd2;
        wr(2, U, "R7 cnt0");
        wr(2, U, "R7 cnt1");
        step(0, 0, 0, 0, 1, 2, N, "R7 replace at len2");
        wr(2, I, "R7 len at thr keeps invalidate");
        step(0, 0, 0, 0, 1, 2, N, "R7 replace at len1");
        wr(2, U, "R7 short run to update");
    endtask

    task automatic t_iso();
        thr = 3'd1;
        wr(3, U, "R8 line3 cnt0");
        wr(3, I, "R8 line3 cnt1");
        step(0, 0, 1, 4, 1, 5, N, "R8 events on other lines");
        wr(3, I, "R8 line3 unaffected");
        wr(4, U, "R8 line4 fresh");
    endtask

    task automatic t_sat();
        thr = 3'd7;
        for (int k = 0; k < 7; k++) wr(6, U, "R5 below 7");
        for (int k = 0; k < 5; k++) wr(6, I, "R5 at saturation");
        step(0, 0, 1, 6, 0, 0, N, "R5 snoop after 12 writes");
        wr(6, I, "R5 saturated length stays at thr");
    endtask

    task automatic t_same();
        thr = 3'd2;
        wr(7, U, "R6 same cnt0");
        step(1, 7, 1, 7, 0, 0, U, "R6 write with snoop");
        wr(7, I, "R6 same-cycle write counted");
        step(0, 0, 1, 7, 0, 0, N, "R6 snoop short");
        wr(7, U, "R6 back to update");
    endtask

    task automatic t_thr0();
        thr = 3'd0;
        wr(5, I, "R9 thr0 fresh line");
        step(0, 0, 1, 5, 0, 0, N, "R9 snoop");
        wr(5, I, "R9 thr0 after run end");
        wr(0, I, "R9 thr0 other line");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run();
        t_repl();
        t_iso();
        t_sat();
        t_same();
        t_thr0();
        @(negedge clk);
        wr_v = 0; sn_v = 0; rp_v = 0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule